// File: doc/BRIEF.md
# Interprocessor Destination Decoder

This block sits beside the command registers of a local interrupt unit and turns a software write of an interprocessor interrupt command into the set of local units that must act on it. The command is 64 bits wide and arrives as two 32-bit writes. A write of the high word only records the destination byte. A write of the low word starts a send: the block combines the low word with the stored destination, the sender's own index and a table that describes every local unit, and one clock later it presents a target bitmask together with the vector, delivery mode and trigger.

The table holds, for each of `NUM_UNITS` slots, a present flag, a physical ID byte, a logical destination byte and a destination-model nibble. Targets can come from a shorthand (self, all, all-but-self) or from the destination field. The destination field is read either as a physical ID or as a logical address, and the logical address is matched in flat or cluster form. Two delivery modes reshape the result. Lowest-priority delivery narrows the mask to a single unit. An INIT with level deasserted delivers no interrupt; instead it flags that each target must reload its arbitration ID from its physical ID.

Top module: `ipi_dest_decoder`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` and `out_arb_sync` are 0 and `out_targets` is all zeros.
- R2: A high-word write stores destination bits 31:24 and produces no output pulse. A low-word write in cycle k gives `out_valid` high for exactly cycle k+1, with `out_vector` equal to low bits 7:0, `out_mode` equal to low bits 10:8 and `out_trigger` equal to low bit 15. Low-word writes in back-to-back cycles give back-to-back results.
- R3: Shorthand code 1 (low bits 19:18) selects only the bit at the sender's index.
- R4: Shorthand code 2 selects every present unit. Shorthand code 3 selects every present unit except the sender.
- R5: With shorthand 0 and physical addressing (low bit 11 = 0), destination 0xFF selects every present unit.
- R6: With shorthand 0 and physical addressing, any other destination selects the lowest-numbered present unit whose physical ID equals it. If no present unit has that ID, the mask is empty.
- R7: With shorthand 0 and logical addressing (low bit 11 = 1), a unit whose model nibble is 0xF matches when the destination and its logical byte have a set bit in common.
- R8: In logical addressing, a unit whose model nibble is 0x0 matches when the upper nibbles of the destination and its logical byte are equal and the lower nibbles share a set bit. A unit with any other model never matches.
- R9: Logical matching considers only slots below the first absent slot in the table.
- R10: Delivery mode 1 (lowest priority) reduces the mask to its lowest-numbered set bit. A mask that was empty stays empty.
- R11: Delivery mode 5 with level (bit 14) 0 and trigger (bit 15) 1 raises `out_arb_sync` with the result pulse. The mask then names the units that reload their arbitration ID. Every other command leaves `out_arb_sync` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_lo | input | 1 | Write strobe for the low command word; starts a send |
| wr_hi | input | 1 | Write strobe for the high command word |
| wr_data | input | 32 | Write data for either word |
| self_idx | input | IDX_W | Table index of the sending unit |
| unit_present | input | NUM_UNITS | One bit per table slot that holds a unit |
| unit_phys_id | input | NUM_UNITS*8 | Physical ID byte of each slot, slot i at bits 8i+7:8i |
| unit_log_dest | input | NUM_UNITS*8 | Logical destination byte of each slot |
| unit_model | input | NUM_UNITS*4 | Destination model nibble of each slot |
| out_valid | output | 1 | One-cycle pulse marking a decoded command |
| out_targets | output | NUM_UNITS | Bitmask of selected units |
| out_mode | output | 3 | Delivery mode of the command |
| out_vector | output | 8 | Interrupt vector of the command |
| out_trigger | output | 1 | Trigger bit of the command |
| out_arb_sync | output | 1 | The targets reload their arbitration ID and receive no interrupt |

## Verification
The assertions take it as given that a low-word write and a high-word write never fall in the same cycle. They also assume `self_idx` names a real slot, and that the table is steady in the cycle of a low-word write. The stimulus drives each write strobe alone for one cycle. It changes the table and the sender index only in cycles that carry no low-word write, so every expected mask is computed from the same table the design samples. Back-to-back low-word writes are the only place where two strobes fall in adjacent cycles.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int ID_W    = 8;
    localparam int MODEL_W = 4;

    localparam logic [ID_W-1:0]    DEST_ALL      = 8'hFF;
    localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
    localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;

    typedef enum logic [2:0] {
        DM_FIXED    = 3'd0,
        DM_LOWEST   = 3'd1,
        DM_SMI      = 3'd2,
        DM_RSVD     = 3'd3,
        DM_NMI      = 3'd4,
        DM_INIT     = 3'd5,
        DM_STARTUP  = 3'd6,
        DM_EXTERNAL = 3'd7
    } dmode_e;

    typedef enum logic [1:0] {
        SH_FIELD  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic [ID_W-1:0] dest;
        shorthand_e      sh;
        logic            trig;
        logic            level;
        logic            logical;
        dmode_e          mode;
        logic [7:0]      vector;
    } ipi_cmd_t;

    function automatic logic flat_hit(input logic [ID_W-1:0] dest,
                                      input logic [ID_W-1:0] ldest);
        return |(dest & ldest);
    endfunction

    function automatic logic cluster_hit(input logic [ID_W-1:0] dest,
                                         input logic [ID_W-1:0] ldest);
        return (dest[7:4] == ldest[7:4]) && (|(dest[3:0] & ldest[3:0]));
    endfunction

    function automatic logic arb_reload(input dmode_e mode,
                                        input logic level,
                                        input logic trig);
        return (mode == DM_INIT) && !level && trig;
    endfunction

endpackage

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] req,
    output logic [WIDTH-1:0] pick
);
    logic [WIDTH:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_chain
        assign pick[i]     = req[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | req[i];
    end

endmodule

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
    import ipi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wr_data,
    output ipi_cmd_t    cmd,
    output logic        fire
);
    logic [ID_W-1:0] dest_q;
    logic            unused_cmd_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q <= '0;
        end else if (wr_hi) begin
            dest_q <= wr_data[31:24];
        end
    end

    always_comb begin
        cmd.vector  = wr_data[7:0];
        cmd.mode    = dmode_e'(wr_data[10:8]);
        cmd.logical = wr_data[11];
        cmd.level   = wr_data[14];
        cmd.trig    = wr_data[15];
        cmd.sh      = shorthand_e'(wr_data[19:18]);
        cmd.dest    = dest_q;
    end

    assign fire            = wr_lo;
    assign unused_cmd_bits = ^{wr_data[23:20], wr_data[17:16], wr_data[13:12]};

    // input assumption behind R2: the two word strobes never coincide
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(wr_lo && wr_hi));

endmodule

// File: rtl/ipi_target_match.sv
module ipi_target_match
    import ipi_pkg::*;
#(
    parameter int NUM_UNITS = 8
) (
    input  logic [ID_W-1:0]            dest,
    input  logic                       logical,
    input  logic [NUM_UNITS-1:0]       present,
    input  logic [NUM_UNITS*ID_W-1:0]  phys_id,
    input  logic [NUM_UNITS*ID_W-1:0]  log_dest,
    input  logic [NUM_UNITS*MODEL_W-1:0] model,
    output logic [NUM_UNITS-1:0]       field_mask
);
    logic [NUM_UNITS-1:0] id_eq;
    logic [NUM_UNITS-1:0] id_first;
    logic [NUM_UNITS-1:0] log_ok;
    logic [NUM_UNITS-1:0] run;

    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
        logic [ID_W-1:0]    pid;
        logic [ID_W-1:0]    lbyte;
        logic [MODEL_W-1:0] mdl;

        assign pid   = phys_id[i*ID_W +: ID_W];
        assign lbyte = log_dest[i*ID_W +: ID_W];
        assign mdl   = model[i*MODEL_W +: MODEL_W];

        assign id_eq[i] = present[i] && (pid == dest);

        always_comb begin
            unique case (mdl)
                MODEL_FLAT:    log_ok[i] = flat_hit(dest, lbyte);
                MODEL_CLUSTER: log_ok[i] = cluster_hit(dest, lbyte);
                default:       log_ok[i] = 1'b0;
            endcase
        end

        if (i == 0) begin : g_head
            assign run[i] = present[i];
        end else begin : g_tail
            assign run[i] = run[i - 1] & present[i];
        end
    end

    ipi_lowest_pick #(.WIDTH(NUM_UNITS)) u_first_id (
        .req  (id_eq),
        .pick (id_first)
    );

    always_comb begin
        if (logical) begin
            field_mask = log_ok & run;
        end else if (dest == DEST_ALL) begin
            field_mask = present;
        end else begin
            field_mask = id_first;
        end
    end

endmodule

// File: rtl/ipi_target_select.sv
module ipi_target_select
    import ipi_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    parameter int IDX_W     = 3
) (
    input  ipi_cmd_t             cmd,
    input  logic [IDX_W-1:0]     self_idx,
    input  logic [NUM_UNITS-1:0] present,
    input  logic [NUM_UNITS-1:0] field_mask,
    output logic [NUM_UNITS-1:0] targets,
    output logic                 arb_sync
);
    localparam logic [NUM_UNITS-1:0] ONE = {{(NUM_UNITS-1){1'b0}}, 1'b1};

    logic [NUM_UNITS-1:0] self_oh;
    logic [NUM_UNITS-1:0] base_mask;
    logic [NUM_UNITS-1:0] lowest;

    assign self_oh = ONE << self_idx;

    always_comb begin
        unique case (cmd.sh)
            SH_SELF:   base_mask = self_oh;
            SH_ALL:    base_mask = present;
            SH_OTHERS: base_mask = present & ~self_oh;
            default:   base_mask = field_mask;
        endcase
    end

    ipi_lowest_pick #(.WIDTH(NUM_UNITS)) u_lowest (
        .req  (base_mask),
        .pick (lowest)
    );

    assign arb_sync = arb_reload(cmd.mode, cmd.level, cmd.trig);
    assign targets  = (cmd.mode == DM_LOWEST) ? lowest : base_mask;

endmodule

// File: rtl/ipi_dest_decoder.sv
module ipi_dest_decoder
    import ipi_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    localparam int IDX_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_lo,
    input  logic                          wr_hi,
    input  logic [31:0]                   wr_data,
    input  logic [IDX_W-1:0]              self_idx,
    input  logic [NUM_UNITS-1:0]          unit_present,
    input  logic [NUM_UNITS*8-1:0]        unit_phys_id,
    input  logic [NUM_UNITS*8-1:0]        unit_log_dest,
    input  logic [NUM_UNITS*4-1:0]        unit_model,
    output logic                          out_valid,
    output logic [NUM_UNITS-1:0]          out_targets,
    output logic [2:0]                    out_mode,
    output logic [7:0]                    out_vector,
    output logic                          out_trigger,
    output logic                          out_arb_sync
);
    ipi_cmd_t             cmd;
    logic                 fire;
    logic [NUM_UNITS-1:0] field_mask;
    logic [NUM_UNITS-1:0] sel_targets;
    logic                 sel_arb;

    ipi_cmd_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .cmd     (cmd),
        .fire    (fire)
    );

    ipi_target_match #(.NUM_UNITS(NUM_UNITS)) u_match (
        .dest       (cmd.dest),
        .logical    (cmd.logical),
        .present    (unit_present),
        .phys_id    (unit_phys_id),
        .log_dest   (unit_log_dest),
        .model      (unit_model),
        .field_mask (field_mask)
    );

    ipi_target_select #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W)) u_select (
        .cmd        (cmd),
        .self_idx   (self_idx),
        .present    (unit_present),
        .field_mask (field_mask),
        .targets    (sel_targets),
        .arb_sync   (sel_arb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_targets  <= '0;
            out_mode     <= '0;
            out_vector   <= '0;
            out_trigger  <= 1'b0;
            out_arb_sync <= 1'b0;
        end else begin
            out_valid    <= fire;
            out_arb_sync <= fire & sel_arb;
            if (fire) begin
                out_targets <= sel_targets;
                out_mode    <= cmd.mode;
                out_vector  <= cmd.vector;
                out_trigger <= cmd.trig;
            end
        end
    end

    a_r2_pulse_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> out_valid);

    a_r2_quiet_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_lo |=> !out_valid);

    a_r3_self_single: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && wr_data[19:18] == 2'd1 && wr_data[10:8] != 3'd1)
        |=> $countones(out_targets) == 1);

    a_r4_others_skip_sender: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && wr_data[19:18] == 2'd3) |=> !out_targets[$past(self_idx)]);

    a_r9_logical_within_table: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && wr_data[11] && wr_data[19:18] == 2'd0)
        |=> (out_targets & ~$past(unit_present)) == '0);

    a_r10_lowest_single: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mode == 3'd1) |-> $onehot0(out_targets));

    a_r11_sync_only_init: assert property (@(posedge clk) disable iff (rst)
        out_arb_sync |-> (out_valid && out_mode == 3'd5 && !out_trigger == 1'b0));

endmodule

// File: tb/ipi_dest_decoder_tb.sv
module ipi_dest_decoder_tb;

    localparam int N    = 8;
    localparam int IDXW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_lo = 1'b0;
    logic            wr_hi = 1'b0;
    logic [31:0]     wr_data = '0;
    logic [IDXW-1:0] self_idx = '0;
    logic [N-1:0]    unit_present = '0;
    logic [N*8-1:0]  unit_phys_id = '0;
    logic [N*8-1:0]  unit_log_dest = '0;
    logic [N*4-1:0]  unit_model = '0;
    logic            out_valid;
    logic [N-1:0]    out_targets;
    logic [2:0]      out_mode;
    logic [7:0]      out_vector;
    logic            out_trigger;
    logic            out_arb_sync;

    always #2 clk = ~clk;

    ipi_dest_decoder #(.NUM_UNITS(N)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .wr_lo         (wr_lo),
        .wr_hi         (wr_hi),
        .wr_data       (wr_data),
        .self_idx      (self_idx),
        .unit_present  (unit_present),
        .unit_phys_id  (unit_phys_id),
        .unit_log_dest (unit_log_dest),
        .unit_model    (unit_model),
        .out_valid     (out_valid),
        .out_targets   (out_targets),
        .out_mode      (out_mode),
        .out_vector    (out_vector),
        .out_trigger   (out_trigger),
        .out_arb_sync  (out_arb_sync)
    );

    typedef struct {
        logic [N-1:0] targets;
        logic [2:0]   mode;
        logic [7:0]   vector;
        logic         trig;
        logic         arb;
        string        tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    logic [7:0] hi_dest = '0;
    bit         done = 0;

    function automatic exp_t model_cmd(input logic [31:0] lo, input string tag);
        exp_t e;
        logic [N-1:0] m;
        logic [7:0] ld;
        logic [3:0] md;
        m = '0;
        case (lo[19:18])
            2'd1: m[self_idx] = 1'b1;
            2'd2: m = unit_present;
            2'd3: begin
                m = unit_present;
                m[self_idx] = 1'b0;
            end
            default: begin
                if (!lo[11]) begin
                    if (hi_dest == 8'hFF) m = unit_present;
                    else begin
                        for (int i = 0; i < N; i++) begin
                            if (unit_present[i] && unit_phys_id[i*8 +: 8] == hi_dest) begin
                                m[i] = 1'b1;
                                break;
                            end
                        end
                    end
                end else begin
                    for (int i = 0; i < N; i++) begin
                        if (!unit_present[i]) break;
                        ld = unit_log_dest[i*8 +: 8];
                        md = unit_model[i*4 +: 4];
                        if (md == 4'hF && (hi_dest & ld) != 0) m[i] = 1'b1;
                        if (md == 4'h0 && hi_dest[7:4] == ld[7:4] &&
                            (hi_dest[3:0] & ld[3:0]) != 0) m[i] = 1'b1;
                    end
                end
            end
        endcase
        if (lo[10:8] == 3'd1) begin
            for (int i = 0; i < N; i++) begin
                if (m[i]) begin
                    m = '0;
                    m[i] = 1'b1;
                    break;
                end
            end
        end
        e.targets = m;
        e.mode    = lo[10:8];
        e.vector  = lo[7:0];
        e.trig    = lo[15];
        e.arb     = (lo[10:8] == 3'd5) && !lo[14] && lo[15];
        e.tag     = tag;
        return e;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected out_valid, targets=%b expected no pulse", out_targets);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_targets !== e.targets || out_mode !== e.mode ||
                    out_vector !== e.vector || out_trigger !== e.trig ||
                    out_arb_sync !== e.arb) begin
                    errors++;
                    $display("FAIL %s: got t=%b m=%0d v=%h tr=%b a=%b expected t=%b m=%0d v=%h tr=%b a=%b",
                             e.tag, out_targets, out_mode, out_vector, out_trigger, out_arb_sync,
                             e.targets, e.mode, e.vector, e.trig, e.arb);
                end
            end
        end
    end

    task automatic send(input logic [31:0] lo, input string tag);
        @(negedge clk);
        wr_lo   = 1'b1;
        wr_data = lo;
        sb.push_back(model_cmd(lo, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        wr_lo   = 1'b0;
        wr_hi   = 1'b0;
        wr_data = '0;
    endtask

    task automatic settle();
        idle();
        idle();
    endtask

    task automatic write_hi(input logic [7:0] d);
        @(negedge clk);
        wr_lo   = 1'b0;
        wr_hi   = 1'b1;
        wr_data = {d, 24'h5A5A5A};
        hi_dest = d;
        @(negedge clk);
        wr_hi   = 1'b0;
        wr_data = '0;
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2: high-word write gave out_valid=%b expected 0", out_valid);
        end
    endtask

    task automatic set_unit(input int i, input logic p, input logic [7:0] id,
                            input logic [7:0] ld, input logic [3:0] md);
        unit_present[i]           = p;
        unit_phys_id[i*8 +: 8]    = id;
        unit_log_dest[i*8 +: 8]   = ld;
        unit_model[i*4 +: 4]      = md;
    endtask

    function automatic logic [31:0] cmd_word(input logic [1:0] sh, input logic trig,
                                             input logic level, input logic logical,
                                             input logic [2:0] mode, input logic [7:0] vec);
        return {12'h0, sh, 2'b00, trig, level, 2'b00, logical, mode, vec};
    endfunction

    task automatic default_table();
        for (int i = 0; i < N; i++) set_unit(i, 1'b1, 8'h10 + 8'(i), 8'h01 << i, 4'hF);
    endtask

    initial begin
        int wd;
        wd = 0;
        while (!done) begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                errors++;
                $display("FAIL watchdog: run did not finish");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        default_table();
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_targets !== '0 || out_arb_sync !== 1'b0) begin
            errors++;
            $display("FAIL R1: valid=%b targets=%b arb=%b expected 0 0 0", out_valid, out_targets, out_arb_sync);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_targets !== '0 || out_arb_sync !== 1'b0) begin
            errors++;
            $display("FAIL R1: after reset valid=%b targets=%b expected 0 0", out_valid, out_targets);
        end

        // R2 / R6: physical match, field positions
        write_hi(8'h13);
        send(cmd_word(2'd0, 1'b1, 1'b1, 1'b0, 3'd0, 8'h41), "R6 physical id match");
        settle();
        // R6: missing ID gives empty mask
        write_hi(8'h77);
        send(cmd_word(2'd0, 1'b0, 1'b0, 1'b0, 3'd4, 8'h02), "R6 physical id missing");
        settle();
        // R6: duplicate ID, lowest slot wins
        set_unit(5, 1'b1, 8'h12, 8'h20, 4'hF);
        write_hi(8'h12);
        send(cmd_word(2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h33), "R6 duplicate id lowest");
        settle();
        // R5: broadcast to present units
        default_table();
        set_unit(6, 1'b0, 8'h16, 8'h40, 4'hF);
        write_hi(8'hFF);
        send(cmd_word(2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h50), "R5 physical broadcast");
        settle();
        // R3 / R4: shorthands
        self_idx = 3'd3;
        send(cmd_word(2'd1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h61), "R3 shorthand self");
        settle();
        send(cmd_word(2'd2, 1'b0, 1'b0, 1'b0, 3'd2, 8'h62), "R4 shorthand all");
        settle();
        send(cmd_word(2'd3, 1'b1, 1'b0, 1'b0, 3'd0, 8'h63), "R4 shorthand others");
        settle();
        // R7: flat logical
        default_table();
        write_hi(8'h25);
        send(cmd_word(2'd0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h70), "R7 logical flat");
        settle();
        // R8: cluster logical and a foreign model
        for (int i = 0; i < N; i++) set_unit(i, 1'b1, 8'h10 + 8'(i), {4'(i / 4), 4'h1 << (i % 4)}, 4'h0);
        set_unit(1, 1'b1, 8'h11, 8'h02, 4'h5);
        write_hi(8'h0B);
        send(cmd_word(2'd0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h80), "R8 logical cluster");
        settle();
        write_hi(8'h1F);
        send(cmd_word(2'd0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h81), "R8 logical cluster second");
        settle();
        // R9: table scan stops at first empty slot
        default_table();
        set_unit(3, 1'b0, 8'h13, 8'h08, 4'hF);
        write_hi(8'hFF);
        send(cmd_word(2'd0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h90), "R9 logical stop at gap");
        settle();
        // R10: lowest priority narrowing
        default_table();
        write_hi(8'h34);
        send(cmd_word(2'd0, 1'b0, 1'b0, 1'b1, 3'd1, 8'hA0), "R10 lowest from logical");
        settle();
        self_idx = 3'd0;
        send(cmd_word(2'd3, 1'b0, 1'b0, 1'b0, 3'd1, 8'hA1), "R10 lowest from others");
        settle();
        write_hi(8'h99);
        send(cmd_word(2'd0, 1'b0, 1'b0, 1'b0, 3'd1, 8'hA2), "R10 lowest empty");
        settle();
        // R11: INIT level deassert versus normal INIT
        write_hi(8'hFF);
        send(cmd_word(2'd0, 1'b1, 1'b0, 1'b0, 3'd5, 8'h00), "R11 init deassert sync");
        settle();
        send(cmd_word(2'd0, 1'b1, 1'b1, 1'b0, 3'd5, 8'h00), "R11 init asserted no sync");
        settle();
        // R2: back-to-back low writes
        self_idx = 3'd6;
        send(cmd_word(2'd1, 1'b0, 1'b0, 1'b0, 3'd0, 8'hB1), "R2 back-to-back first");
        send(cmd_word(2'd3, 1'b1, 1'b0, 1'b0, 3'd4, 8'hB2), "R2 back-to-back second");
        settle();
        settle();
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d results missing, expected 0", sb.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule